// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a two-wire serial slave that lets an external host read and write a bank of 8-bit control registers. SCL and SDA are treated as ordinary inputs. Both pass through synchronizers clocked by the system clock, and start, repeated-start and stop conditions and SCL edges are found by comparing successive sampled values. The slave answers one 7-bit device address. It pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

In a write transfer, the first byte after the address byte loads a register pointer. Every byte after that is stored at the pointer, and the pointer then moves to the next register. A read transfer returns bytes starting at the pointer most recently set. A host normally sets that pointer in a short write phase, then issues a repeated start and a read address byte. The pointer also steps after each byte read. It wraps at the end of the bank. The whole bank is visible at all times on a flat parallel output, which feeds the rest of the chip.

Top module: `sreg_slave`

## Requirements
- R1: After reset, sda_oe is low and every register reads 0x00 on regs_o.
- R2: A falling SDA while SCL is high is a start. A start given in the middle of a transfer (repeated start) also releases SDA and begins a new address byte.
- R3: The first byte after a start is received MSB first. Bits 7:1 are compared with DEV_ADDR and bit 0 gives the direction (0 write, 1 read). On a match the slave holds sda_oe high through the ninth SCL pulse. On a mismatch it gives no acknowledge and ignores everything up to the next start, so registers are unchanged.
- R4: In a write transfer, the byte after the address byte sets the pointer to its low log2(NUM_REGS) bits and is acknowledged.
- R5: Each further write byte is stored in the register at the pointer and acknowledged, and the pointer then advances by one modulo NUM_REGS (63 wraps to 0 by default).
- R6: In a read transfer, the slave sends the register at the pointer MSB first, presenting each bit after an SCL falling edge. The pointer advances by one modulo NUM_REGS after every byte sent.
- R7: The pointer keeps its value across a repeated start and across a stop. A read that follows without a new pointer byte continues from where the last transfer left off.
- R8: A master NACK (SDA high in the acknowledge slot after a read byte) ends the read. The slave then leaves SDA released until the next start.
- R9: A rising SDA while SCL is high is a stop. It releases SDA and makes the slave idle. Bits clocked after a stop without a new start are not acknowledged and change no register.
- R10: sda_oe changes only in the cycle after a detected SCL falling edge, or after a start or stop.
- R11: Bits [8*i+7:8*i] of regs_o hold register i, and a written byte appears there one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | NUM_REGS*8 | All registers, register i in bits [8*i+7:8*i] |

## Verification
The bench builds the block with the default 64-entry bank, two synchronizer stages and device address 0x4C. With 64 entries, bursts that start at 62 or 63 cross the pointer wrap in both directions. Wrong addresses that differ from 0x4C in the lowest and in the highest address bit show that all seven bits are compared. Each serial half-period lasts several system clocks, which leaves room for the synchronizer delay. This lets the bench sample the acknowledge and the read data near the end of each SCL phase, and check that the enable never moves while SCL is high.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // Transfer phase of the serial link
   typedef enum logic [2:0] {
      PH_IDLE,   // waiting for a start
      PH_DEV,    // receiving the device address byte
      PH_PTR,    // receiving the pointer byte
      PH_WR,     // receiving data bytes
      PH_RD      // sending data bytes
   } phase_t;

   localparam int BYTE_W   = 8;
   localparam int ACK_SLOT = BYTE_W + 1;   // SCL pulse count that ends the ack slot

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sreg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sreg_line.sv
module sreg_line #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_s, scl_d, sda_d;

   sreg_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );
   sreg_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   // SDA may only move while SCL is high to signal a condition
   assign start_det = scl_s & scl_d &  sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d &  sda_s;
   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
   parameter int         NUM_REGS = 64,
   parameter int         PTR_W    = 6,
   parameter logic [7:0] RST_VAL  = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [PTR_W-1:0]        waddr,
   input  logic [7:0]              wdata,
   input  logic [PTR_W-1:0]        raddr,
   output logic [7:0]              rdata,
   output logic [NUM_REGS*8-1:0]   flat
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           r <= RST_VAL;
         else if (we && waddr == PTR_W'(i))    r <= wdata;
      end
      assign flat[i*8 +: 8] = r;
   end

   assign rdata = flat[{raddr, 3'b000} +: 8];

endmodule

// File: rtl/sreg_link.sv
module sreg_link
   import sreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h4C,
   parameter int         PTR_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_s,
   input  logic [7:0]       rdata,
   output logic             we,
   output logic [PTR_W-1:0] ptr,
   output logic [7:0]       wdata,
   output logic             sda_oe
);

   phase_t     phase;
   logic [3:0] bitc;      // SCL pulses seen in the current byte
   logic [7:0] rx_sh;
   logic [7:0] tx_sh;
   logic       rd_dir;
   logic       m_nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         bitc   <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         ptr    <= '0;
         rd_dir <= 1'b0;
         m_nack <= 1'b0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         phase  <= PH_DEV;
         bitc   <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         phase  <= PH_IDLE;
         bitc   <= '0;
         sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
         if (scl_rise) begin
            if (bitc < 4'(BYTE_W)) rx_sh  <= {rx_sh[6:0], sda_s};
            else                   m_nack <= sda_s;
            bitc <= bitc + 4'd1;
         end else if (scl_fall) begin
            if (bitc == 4'(BYTE_W)) begin
               // eight bits done: open the acknowledge slot
               unique case (phase)
                  PH_DEV: begin
                     if (rx_sh[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rd_dir <= rx_sh[0];
                     end else begin
                        phase  <= PH_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end
                  PH_PTR: begin
                     ptr    <= rx_sh[PTR_W-1:0];
                     sda_oe <= 1'b1;
                  end
                  PH_WR: begin
                     ptr    <= ptr + PTR_W'(1);
                     sda_oe <= 1'b1;
                  end
                  PH_RD: begin
                     ptr    <= ptr + PTR_W'(1);
                     sda_oe <= 1'b0;
                  end
                  default: sda_oe <= 1'b0;
               endcase
            end else if (bitc == 4'(ACK_SLOT)) begin
               // acknowledge slot over: choose what follows
               bitc   <= '0;
               sda_oe <= 1'b0;
               case (phase)
                  PH_DEV: begin
                     if (rd_dir) begin
                        phase  <= PH_RD;
                        tx_sh  <= rdata;
                        sda_oe <= ~rdata[7];
                     end else begin
                        phase  <= PH_PTR;
                     end
                  end
                  PH_PTR: phase <= PH_WR;
                  PH_RD: begin
                     if (m_nack) begin
                        phase <= PH_IDLE;
                     end else begin
                        tx_sh  <= rdata;
                        sda_oe <= ~rdata[7];
                     end
                  end
                  default: ;
               endcase
            end else if (phase == PH_RD && bitc != 4'd0) begin
               tx_sh  <= {tx_sh[6:0], 1'b0};
               sda_oe <= ~tx_sh[6];
            end
         end
      end
   end

   assign we    = (phase == PH_WR) && scl_fall && (bitc == 4'(BYTE_W))
                  && !start_det && !stop_det;
   assign wdata = rx_sh;

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h4C,
   parameter int         NUM_REGS    = 64,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RST_VAL     = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] regs_o
);

   localparam int PTR_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 256 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
      $error("sreg_slave: NUM_REGS must be a power of two from 2 to 256");
   end

   logic             sda_s, start_det, stop_det, scl_rise, scl_fall;
   logic             we;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       wdata, rdata;

   sreg_line #(.STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   sreg_link #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_link (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s), .rdata(rdata),
      .we(we), .ptr(ptr), .wdata(wdata), .sda_oe(sda_oe)
   );

   sreg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .RST_VAL(RST_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(wdata),
      .raddr(ptr), .rdata(rdata), .flat(regs_o)
   );

endmodule

// File: rtl/sreg_chk.sv
module sreg_chk #(
   parameter int NUM_REGS = 64,
   parameter int PTR_W    = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  scl_fall,
   input logic                  we,
   input logic [PTR_W-1:0]      ptr,
   input logic [7:0]            wdata,
   input logic                  sda_oe,
   input logic [NUM_REGS*8-1:0] regs_o
);

   logic             wr_q;
   logic [PTR_W-1:0] wa_q;
   logic [7:0]       wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         wa_q <= '0;
         wd_q <= '0;
      end else begin
         wr_q <= we;
         wa_q <= ptr;
         wd_q <= wdata;
      end
   end

   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !sda_oe); // R2
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R9
   AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(scl_fall)); // R10
   AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R10
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) we |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R5
   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) wr_q |-> regs_o[{wa_q, 3'b000} +: 8] == wd_q); // R11

endmodule

bind sreg_slave sreg_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
   .scl_fall(scl_fall), .we(we), .ptr(ptr), .wdata(wdata),
   .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/tb_sreg_slave.sv
module tb_sreg_slave;

   localparam int         CLK_PERIOD = 10;
   localparam int         HALF       = 8;
   localparam logic [6:0] ADDR       = 7'h4C;
   localparam int         NREG       = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl = 1'b1;
   logic            sda_m = 1'b1;
   logic            sda_oe;
   logic            sda_line;
   logic [NREG*8-1:0] regs;

   assign sda_line = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   sreg_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .regs_o(regs)
   );

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [7:0]  model [NREG];
   int          mptr = 0;

   task automatic finish_sim();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int wrap(input int v);
      return v % NREG;
   endfunction

   task automatic chk_regs(input string tag);
      int bad = -1;
      for (int i = NREG - 1; i >= 0; i--)
         if (regs[i*8 +: 8] !== model[i]) bad = i;
      if (bad < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, tag, {24'd0, regs[bad*8 +: 8]}, {24'd0, model[bad]});
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(HALF);
      scl = 1'b1;   wt(HALF);
      sda_m = 1'b0; wt(HALF);
      scl = 1'b0;   wt(HALF);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(HALF);
      scl = 1'b1;   wt(HALF);
      sda_m = 1'b1; wt(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(HALF);
         scl = 1'b1;   wt(HALF);
         scl = 1'b0;
      end
      sda_m = 1'b1; wt(HALF);
      scl = 1'b1;   wt(HALF/2);
      acked = (sda_line == 1'b0);
      wt(HALF/2);
      scl = 1'b0;   wt(HALF);
   endtask

   // receive one byte; steady reports sda_oe unchanged in every SCL-high phase
   task automatic recv_byte(input bit mack, output logic [7:0] b, output bit steady);
      logic o1;
      steady = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(HALF);
         scl = 1'b1; wt(1);
         o1 = sda_oe; wt(HALF/2 - 1);
         b[i] = sda_line; wt(HALF/2);
         if (sda_oe !== o1) steady = 1'b0;
         scl = 1'b0;
      end
      sda_m = ~mack; wt(HALF);
      scl = 1'b1;    wt(HALF);
      scl = 1'b0;    sda_m = 1'b1; wt(HALF);
   endtask

   task automatic write_txn(input int p, input int n);
      bit ack;
      logic [7:0] d;
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R3 write address ack", ack, 1);
      send_byte(8'(p), ack);        chk(ack, "R4 pointer byte ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         send_byte(d, ack);         chk(ack, "R5 data byte ack", ack, 1);
         model[wrap(p + k)] = d;
      end
      bus_stop();
      mptr = wrap(p + n);
      wt(4);
      chk_regs("R5 R11 registers after write");
   endtask

   // set_ptr: write pointer then repeated start; otherwise read from kept pointer
   task automatic read_txn(input int p, input int n, input bit set_ptr);
      bit ack, steady;
      logic [7:0] d;
      bus_start();
      if (set_ptr) begin
         send_byte({ADDR, 1'b0}, ack); chk(ack, "R3 write address ack", ack, 1);
         send_byte(8'(p), ack);        chk(ack, "R4 pointer byte ack", ack, 1);
         mptr = wrap(p);
         bus_start();
      end
      send_byte({ADDR, 1'b1}, ack);    chk(ack, "R3 read address ack after R2 restart", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, d, steady);
         chk(d == model[wrap(mptr + k)], "R6 R7 read data", d, model[wrap(mptr + k)]);
         chk(steady, "R10 enable steady while SCL high", steady, 1);
      end
      bus_stop();
      mptr = wrap(mptr + n);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      bit ack, steady;
      logic [7:0] d;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;

      wt(5);
      chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      wt(5);
      chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
      chk_regs("R1 registers after reset");

      // single and wrapping bursts
      write_txn(5, 1);
      write_txn(62, 4);
      read_txn(5, 1, 1);
      read_txn(62, 4, 1);
      // R7: pointer kept across stop (ended at 2)
      read_txn(0, 2, 0);

      // R3: wrong address, LSB and MSB differing
      bus_start();
      send_byte({7'h4D, 1'b0}, ack); chk(!ack, "R3 no ack wrong address lsb", ack, 0);
      send_byte(8'h10, ack);         chk(!ack, "R3 ignored byte after mismatch", ack, 0);
      send_byte(8'hA5, ack);         chk(!ack, "R3 ignored byte after mismatch", ack, 0);
      bus_stop();
      bus_start();
      send_byte({7'h0C, 1'b1}, ack); chk(!ack, "R3 no ack wrong address msb", ack, 0);
      recv_byte(1'b0, d, steady);    chk(d == 8'hFF, "R3 mismatch read line idle", d, 8'hFF);
      bus_stop();
      wt(4);
      chk_regs("R3 registers unchanged after mismatch");

      // R8: NACK ends read, following clocks see a released line
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R3 write address ack", ack, 1);
      send_byte(8'd10, ack);        chk(ack, "R4 pointer byte ack", ack, 1);
      bus_start();
      send_byte({ADDR, 1'b1}, ack); chk(ack, "R2 read address after restart", ack, 1);
      recv_byte(1'b0, d, steady);   chk(d == model[10], "R6 read before nack", d, model[10]);
      recv_byte(1'b0, d, steady);   chk(d == 8'hFF, "R8 line released after nack", d, 8'hFF);
      chk(sda_oe == 1'b0, "R8 enable low after nack", sda_oe, 0);
      bus_stop();
      mptr = 11;

      // R2: repeated start inside a write resets to address reception
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R3 write address ack", ack, 1);
      send_byte(8'd20, ack);        chk(ack, "R4 pointer byte ack", ack, 1);
      send_byte(8'h3C, ack);        chk(ack, "R5 data byte ack", ack, 1);
      model[20] = 8'h3C;
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R2 address after repeated start", ack, 1);
      send_byte(8'd30, ack);        chk(ack, "R2 new pointer after restart", ack, 1);
      send_byte(8'hC3, ack);        chk(ack, "R5 data byte ack", ack, 1);
      model[30] = 8'hC3;
      bus_stop();
      mptr = 31;
      wt(4);
      chk_regs("R2 R11 registers after restart write");

      // R4: pointer byte above the bank size keeps its low bits (0xC7 -> 7)
      write_txn(8'hC7, 1);
      read_txn(7, 1, 1);

      // R9: clocking after stop without a start
      chk(sda_oe == 1'b0, "R9 enable low after stop", sda_oe, 0);
      scl = 1'b0; wt(HALF);
      send_byte({ADDR, 1'b0}, ack); chk(!ack, "R9 no ack without start", ack, 0);
      send_byte(8'h00, ack);        chk(!ack, "R9 no ack without start", ack, 0);
      send_byte(8'h77, ack);        chk(!ack, "R9 no ack without start", ack, 0);
      bus_stop();
      wt(4);
      chk_regs("R9 registers unchanged without start");

      // constrained random transfers
      for (int t = 0; t < 24; t++) begin
         int p, n;
         p = int'($urandom % NREG);
         n = 1 + int'($urandom % 4);
         if ($urandom % 2 == 0) write_txn(p, n);
         else                   read_txn(p, n, 1);
      end

      finish_sim();
   end

endmodule